// File: doc/BRIEF.md
# Sync-Gated Transmit Start Sequencer

This block is the transmit control for a single channel. A frame may begin only when three conditions are true in the same cycle: software has set its start enable, the transmit FIFO holds at least a programmed number of words, and the block's own periodic sync pulse is present. The sync pulse comes from an internal down-counter whose period software programs. While a frame is in progress, the block issues one FIFO read strobe per word until it has read the programmed word count. It then raises a single-cycle completion pulse that feeds the interrupt logic.

Software stops transmission gracefully by clearing the start enable. A frame already under way still runs to completion, and the machine then rests in idle. A synchronous clear input, and the asynchronous reset, both abandon any frame at once. If the FIFO runs dry in the middle of a frame, the block holds its place and waits for more data. It never shortens the frame.

Top module: `tx_start_seq`

## Requirements
- R1: `frame_active` rises only in the cycle after one in which the machine was waiting and `start_en`, data-ready and `sync_pulse` were all high together. Waiting begins one cycle after `start_en` is seen high in idle.
- R2: Data-ready is true when `fifo_level` is greater than or equal to `ready_thresh`. A level one below the threshold is not ready.
- R3: With `sync_period` = P (nonzero), `sync_pulse` is high for one cycle in every P cycles. The first pulse comes in the cycle after the first clock edge following reset release. With P = 0, `sync_pulse` stays low.
- R4: While `frame_active` is high and `fifo_level` is nonzero, `word_rd` is high. A frame issues exactly `frame_words` reads.
- R5: While `frame_active` is high and `fifo_level` is zero, `word_rd` is low and `frame_active` stays high.
- R6: Clearing `start_en` during a frame does not shorten it. After the frame's completion pulse the machine returns to idle.
- R7: `frame_done` is high for exactly one cycle. It comes in the cycle after the clock edge that takes the last read, and `frame_active` is low during that cycle.
- R8: `seq_clr` high at a clock edge forces idle. From the next cycle `frame_active` is low, and no `frame_done` follows for the aborted frame.
- R9: While `rst_n` is low, `frame_active`, `word_rd`, `frame_done` and `sync_pulse` are all low.
- R10: If `start_en` is still high at completion, the machine waits for the next sync pulse before it starts another frame. It does not start a frame on the cycle right after `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_clr | input | 1 | Synchronous abort to idle |
| start_en | input | 1 | Software transmit enable |
| fifo_level | input | LVL_W | Words currently in the transmit FIFO |
| ready_thresh | input | LVL_W | Minimum level for data-ready |
| sync_period | input | PER_W | Sync pulse period in cycles, 0 disables |
| frame_words | input | CNT_W | Words per frame |
| frame_active | output | 1 | A frame is being sent |
| word_rd | output | 1 | Read one word from the FIFO this cycle |
| frame_done | output | 1 | One-cycle frame completion pulse |
| sync_pulse | output | 1 | Internal sync pulse |

## Verification
A sync counter that is off by one shows up as a `sync_pulse` one cycle out of place, and this is visible within one period of reset release. A wrong state or remaining-word count shows up at `word_rd` and `frame_done`. Either a read is missing or extra, or the completion pulse is early or late, and the fault is seen within the same frame, one cycle after the faulty edge. A wrong start decision shows up as `frame_active` rising in a cycle that does not follow a combined enable, ready and sync cycle.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2,
    ST_DONE = 2'd3
  } tx_state_e;
endpackage

// File: rtl/tx_sync_gen.sv
module tx_sync_gen #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  output logic             pulse
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;

  always_comb begin
    if (period == '0) begin
      cnt_d   = '0;
      pulse_d = 1'b0;
    end else if (cnt_q == '0) begin
      cnt_d   = PER_W'(period - 1'b1);
      pulse_d = 1'b1;
    end else begin
      cnt_d   = PER_W'(cnt_q - 1'b1);
      pulse_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/tx_ready_cmp.sv
module tx_ready_cmp #(
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  output logic             ready,
  output logic             nonempty
);
  assign ready    = (level >= thresh);
  assign nonempty = (level != '0);
endmodule

// File: rtl/tx_seq_fsm.sv
module tx_seq_fsm
  import tx_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start_en,
  input  logic             ready,
  input  logic             sync,
  input  logic             nonempty,
  input  logic [CNT_W-1:0] words,
  output logic             active,
  output logic             rd,
  output logic             done
);
  tx_state_e        st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             rem_en, load;

  assign active = (st_q == ST_SEND);
  assign rd     = active && nonempty;
  assign done   = (st_q == ST_DONE);
  assign load   = (st_q == ST_WAIT) && start_en && ready && sync;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_en) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!start_en)  st_d = ST_IDLE;
        else if (load)  st_d = (words == '0) ? ST_DONE : ST_SEND;
      end
      ST_SEND: if (rd && rem_q == CNT_W'(1)) st_d = ST_DONE;
      ST_DONE: st_d = start_en ? ST_WAIT : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (clr) st_d = ST_IDLE;
  end

  always_comb begin
    rem_en = load || rd;
    rem_d  = load ? words : CNT_W'(rem_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end
endmodule

// File: rtl/tx_start_seq.sv
module tx_start_seq #(
  parameter int LVL_W = 6,
  parameter int PER_W = 12,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_clr,
  input  logic             start_en,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] ready_thresh,
  input  logic [PER_W-1:0] sync_period,
  input  logic [CNT_W-1:0] frame_words,
  output logic             frame_active,
  output logic             word_rd,
  output logic             frame_done,
  output logic             sync_pulse
);
  logic data_ready, fifo_nonempty;

  tx_sync_gen #(.PER_W(PER_W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (sync_period),
    .pulse  (sync_pulse)
  );

  tx_ready_cmp #(.LVL_W(LVL_W)) u_rdy (
    .level    (fifo_level),
    .thresh   (ready_thresh),
    .ready    (data_ready),
    .nonempty (fifo_nonempty)
  );

  tx_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (seq_clr),
    .start_en (start_en),
    .ready    (data_ready),
    .sync     (sync_pulse),
    .nonempty (fifo_nonempty),
    .words    (frame_words),
    .active   (frame_active),
    .rd       (word_rd),
    .done     (frame_done)
  );
endmodule

// File: rtl/tx_start_seq_chk.sv
module tx_start_seq_chk #(
  parameter int LVL_W = 6,
  parameter int PER_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seq_clr,
  input logic             start_en,
  input logic [LVL_W-1:0] fifo_level,
  input logic [LVL_W-1:0] ready_thresh,
  input logic [PER_W-1:0] sync_period,
  input logic             frame_active,
  input logic             word_rd,
  input logic             frame_done,
  input logic             sync_pulse
);
  AST_START_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |-> $past(start_en) && $past(sync_pulse) &&
                            $past(fifo_level >= ready_thresh)); // R1

  AST_SYNC_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_period == '0) |=> !sync_pulse); // R3

  AST_RD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    word_rd |-> frame_active && (fifo_level != '0)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !frame_active ##1 !frame_done); // R7

  AST_CLR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_clr |=> !frame_active && !frame_done); // R8

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_active); // R10
endmodule

bind tx_start_seq tx_start_seq_chk #(.LVL_W(LVL_W), .PER_W(PER_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .seq_clr      (seq_clr),
  .start_en     (start_en),
  .fifo_level   (fifo_level),
  .ready_thresh (ready_thresh),
  .sync_period  (sync_period),
  .frame_active (frame_active),
  .word_rd      (word_rd),
  .frame_done   (frame_done),
  .sync_pulse   (sync_pulse)
);

// File: tb/tx_start_seq_tb.sv
module tx_start_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 6;
  localparam int PER_W = 12;
  localparam int CNT_W = 8;
  localparam int NV    = 24;

  // row: [8] start_en, [7:4] fifo_level, [3] active, [2] rd, [1] done, [0] sync
  // sync_period = 4, ready_thresh = 2, frame_words = 3 for the whole table
  localparam logic [8:0] VEC [NV] = '{
    9'b0_0000_0000, // 0  idle after reset
    9'b1_0000_0001, // 1  sync while idle: R1 no start
    9'b1_0001_0000, // 2  waiting, level 1 < 2 : R2
    9'b1_0010_0000, // 3  ready, no sync
    9'b1_0010_0000, // 4
    9'b1_0010_0001, // 5  all three present
    9'b1_0010_1100, // 6  first read
    9'b1_0000_1000, // 7  empty: stall R5
    9'b0_0001_1100, // 8  start cleared mid-frame R6
    9'b0_0001_1101, // 9  last read
    9'b0_0001_0010, // 10 done pulse R7
    9'b0_0101_0000, // 11 idle despite ready R6
    9'b1_0101_0000, // 12
    9'b1_0101_0001, // 13 sync in wait
    9'b1_0101_1100, // 14
    9'b1_0101_1100, // 15
    9'b1_0101_1100, // 16
    9'b1_0101_0011, // 17 done, start still set R10
    9'b1_0001_0000, // 18 not ready
    9'b1_0001_0000, // 19
    9'b1_0001_0000, // 20
    9'b1_0001_0001, // 21 sync but not ready R2
    9'b0_0001_0000, // 22
    9'b1_0101_0000  // 23 back in idle
  };

  logic             clk, rst_n, seq_clr, start_en;
  logic [LVL_W-1:0] fifo_level, ready_thresh;
  logic [PER_W-1:0] sync_period;
  logic [CNT_W-1:0] frame_words;
  logic             frame_active, word_rd, frame_done, sync_pulse;

  int n_chk, n_bad;
  bit finished;

  tx_start_seq #(.LVL_W(LVL_W), .PER_W(PER_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .seq_clr(seq_clr), .start_en(start_en),
    .fifo_level(fifo_level), .ready_thresh(ready_thresh),
    .sync_period(sync_period), .frame_words(frame_words),
    .frame_active(frame_active), .word_rd(word_rd),
    .frame_done(frame_done), .sync_pulse(sync_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    bit seen;
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; seq_clr = 1'b0; start_en = 1'b0;
    fifo_level = '0; ready_thresh = LVL_W'(2);
    sync_period = PER_W'(4); frame_words = CNT_W'(3);
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "active in reset", frame_active, 1'b0);
    chk("R9", "sync in reset", sync_pulse, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i == 0) rst_n = 1'b1;
      start_en   = VEC[i][8];
      fifo_level = LVL_W'(VEC[i][7:4]);
      #1;
      chk("R1", $sformatf("v%0d active", i), frame_active, VEC[i][3]);
      chk("R4", $sformatf("v%0d rd", i), word_rd, VEC[i][2]);
      chk("R7", $sformatf("v%0d done", i), frame_done, VEC[i][1]);
      chk("R3", $sformatf("v%0d sync", i), sync_pulse, VEC[i][0]);
    end

    // R9: asynchronous reset while waiting
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9", "active after reset", frame_active, 1'b0);
    chk("R9", "rd after reset", word_rd, 1'b0);
    chk("R9", "done after reset", frame_done, 1'b0);
    chk("R9", "sync after reset", sync_pulse, 1'b0);

    // R3: period zero disables sync, so no frame can start
    @(negedge clk);
    sync_period = '0; start_en = 1'b1; fifo_level = LVL_W'(5);
    rst_n = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); #1;
      chk("R3", "sync with period 0", sync_pulse, 1'b0);
      chk("R1", "no start without sync", frame_active, 1'b0);
    end

    // R8: start a frame, then abort it with seq_clr
    @(negedge clk);
    sync_period = PER_W'(3);
    seen = 1'b0;
    for (int k = 0; k < 12 && !seen; k++) begin
      @(negedge clk); #1;
      if (frame_active) seen = 1'b1;
    end
    chk("R1", "frame starts once sync enabled", seen, 1'b1);
    seq_clr = 1'b1;
    @(negedge clk);
    seq_clr = 1'b0; start_en = 1'b0;
    #1;
    chk("R8", "active after clear", frame_active, 1'b0);
    chk("R8", "done after clear", frame_done, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk("R8", "no done for aborted frame", frame_done, 1'b0);
      chk("R8", "no reads after abort", word_rd, 1'b0);
    end

    wrap_up();
  end
endmodule